// File: doc/BRIEF.md
# Video line clamp pulse generator

This block runs on the pixel clock and produces a clamp-enable pulse once per video line. The pulse falls in the back porch, where the input carries a clean black reference. It watches a horizontal sync input and finds the edge where sync ends. After that edge it waits a programmable number of pixel periods, then holds clamp high for a second programmable number of pixel periods. The leading edge of sync never starts the timing, so the clamp does not land on the sync tip.

For each of three colour channels the block also gives the code that the channel's black-level loop should aim for. That code is 0x00 for ground clamping, or 0x80 for midscale clamping of colour-difference components. A small register port holds the placement, duration, channel-select and sync-polarity settings. Placement, duration and channel-select values that software writes are held back until the next sync trailing edge. This way a line that is already running is never split between old and new settings.

Top module: `clamp_pulse_gen`

## Requirements
- R1: Timing starts only from the trailing edge of sync. The leading edge has no effect, and clamp_en stays low for as long as sync is held active.
- R2: The 8-bit placement register at address 0x05 (value P) sets the delay. hsync_in passes through two synchroniser flops. The clock edge that first samples the trailing level counts as edge 1, and clamp_en rises after clock edge P+3. With P=0, clamp_en rises on the first pixel clock after the edge is detected.
- R3: The 8-bit duration register at address 0x06 (value D) keeps clamp_en high for exactly D consecutive pixel clocks. D=0 gives no pulse on that line.
- R4: Reset leaves the registers at these values: placement 0x08, duration 0x14, channel select 0x00 and sync control 0x01. After reset clamp_en is 0 and all three targets are 0x00.
- R5: Register 0x11 holds the channel selects. Bit 4 controls target_r, bit 5 target_g and bit 6 target_b. When a bit is clear its target is 0x00, and when it is set its target is 0x80. Bits 0 to 3 and bit 7 read back as written and do not change any target.
- R6: Bit 0 of register 0x12 sets the sync polarity. A value of 1 means sync is active high, so the falling edge is the trailing edge. A value of 0 means sync is active low, so the rising edge is the trailing edge. Bits 7:1 of this register read as 0. A polarity write takes effect at once.
- R7: A new trailing edge may arrive while a placement or clamp count is still running. In that case clamp_en drops and the whole sequence starts again from the new edge.
- R8: Writes to 0x05, 0x06 and 0x11 take effect only at the next trailing edge. A line already in progress keeps its pulse length, and the targets change only at a trailing edge.
- R9: reg_rdata shows the written value of the register selected by reg_addr from the clock after the write, whether or not that value is in force yet. Unmapped addresses read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous to clk |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| clamp_en | output | 1 | Clamp pulse |
| target_r | output | 8 | Clamp target code, red / V channel |
| target_g | output | 8 | Clamp target code, green / Y channel |
| target_b | output | 8 | Clamp target code, blue / U channel |

## Verification
The bench compares clamp_en with the expected value at every pixel clock. It does this for random lines with random placement, duration and polarity, so an off-by-one in either count shows up as a shifted or stretched window. Several directed lines cover specific cases. A long sync pulse with zero placement separates leading-edge timing from trailing-edge timing. A zero duration separates "no pulse" from a wrapped 256-cycle pulse. A second sync pulse in the middle of the clamp shows whether the running count is restarted or allowed to finish. Writes made in the middle of a line, and target codes checked before and after the next edge, show whether new settings were held back until that edge.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
    localparam int RW = 8;
    localparam logic [RW-1:0] ADDR_PLACE = 8'h05;
    localparam logic [RW-1:0] ADDR_DUR   = 8'h06;
    localparam logic [RW-1:0] ADDR_SEL   = 8'h11;
    localparam logic [RW-1:0] ADDR_SYNC  = 8'h12;
    localparam int SEL_LSB = 4;
    localparam logic [RW-1:0] CODE_GND = 8'h00;
    localparam logic [RW-1:0] CODE_MID = 8'h80;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CLAMP} tmr_state_e;

    typedef struct packed {
        logic [RW-1:0] place;
        logic [RW-1:0] dur;
        logic [RW-1:0] sel;
    } line_cfg_t;

    localparam line_cfg_t CFG_RESET = '{place: 8'h08, dur: 8'h14, sel: 8'h00};
endpackage

// File: rtl/clamp_sync.sv
module clamp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    input  logic active_high,
    output logic trail
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     synced;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], hsync_in};
        synced    = st_q.pipe[STAGES-1];
        st_d.last = synced;
        trail     = active_high ? (st_q.last & ~synced) : (~st_q.last & synced);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/clamp_regs.sv
module clamp_regs
    import clamp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] addr,
    input  logic [RW-1:0] wdata,
    input  logic          trail,
    output logic [RW-1:0] rdata,
    output line_cfg_t     stage_cfg,
    output line_cfg_t     act_cfg,
    output logic          active_high
);
    typedef struct packed {
        line_cfg_t stage;
        line_cfg_t act;
        logic      pol;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trail) st_d.act = st_q.stage;
        if (wr_en) begin
            case (addr)
                ADDR_PLACE: st_d.stage.place = wdata;
                ADDR_DUR:   st_d.stage.dur   = wdata;
                ADDR_SEL:   st_d.stage.sel   = wdata;
                ADDR_SYNC:  st_d.pol         = wdata[0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADDR_PLACE: rdata = st_q.stage.place;
            ADDR_DUR:   rdata = st_q.stage.dur;
            ADDR_SEL:   rdata = st_q.stage.sel;
            ADDR_SYNC:  rdata = {{(RW-1){1'b0}}, st_q.pol};
            default:    rdata = '0;
        endcase
    end

    assign stage_cfg   = st_q.stage;
    assign act_cfg     = st_q.act;
    assign active_high = st_q.pol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stage <= CFG_RESET;
            st_q.act   <= CFG_RESET;
            st_q.pol   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
    import clamp_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trail,
    input  logic [CW-1:0] next_place,
    input  logic [CW-1:0] next_dur,
    input  logic [CW-1:0] act_dur,
    output logic          clamp
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        tmr_state_e    state;
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trail) begin
            if (next_place != '0) begin
                st_d.state = ST_WAIT;
                st_d.cnt   = next_place;
            end else if (next_dur != '0) begin
                st_d.state = ST_CLAMP;
                st_d.cnt   = next_dur;
            end else begin
                st_d.state = ST_IDLE;
                st_d.cnt   = '0;
            end
        end else begin
            case (st_q.state)
                ST_WAIT: begin
                    if (st_q.cnt == ONE) begin
                        st_d.state = (act_dur != '0) ? ST_CLAMP : ST_IDLE;
                        st_d.cnt   = act_dur;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                ST_CLAMP: begin
                    if (st_q.cnt == ONE) begin
                        st_d.state = ST_IDLE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    assign clamp = (st_q.state == ST_CLAMP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ST_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
    import clamp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NCH         = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync_in,
    input  logic          reg_wr_en,
    input  logic [RW-1:0] reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output logic          clamp_en,
    output logic [RW-1:0] target_r,
    output logic [RW-1:0] target_g,
    output logic [RW-1:0] target_b
);
    logic          trail;
    logic          active_high;
    line_cfg_t     stage_cfg;
    line_cfg_t     act_cfg;
    logic [RW-1:0] tgt [NCH];

    clamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_in   (hsync_in),
        .active_high(active_high),
        .trail      (trail)
    );

    clamp_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .trail      (trail),
        .rdata      (reg_rdata),
        .stage_cfg  (stage_cfg),
        .act_cfg    (act_cfg),
        .active_high(active_high)
    );

    clamp_timer #(.CW(RW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .trail     (trail),
        .next_place(stage_cfg.place),
        .next_dur  (stage_cfg.dur),
        .act_dur   (act_cfg.dur),
        .clamp     (clamp_en)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_tgt
        assign tgt[ch] = act_cfg.sel[SEL_LSB + ch] ? CODE_MID : CODE_GND;
    end

    assign target_r = tgt[0];
    assign target_g = tgt[1];
    assign target_b = tgt[2];
endmodule

// File: rtl/clamp_pulse_gen_chk.sv
module clamp_pulse_gen_chk
    import clamp_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          trail,
    input logic [RW-1:0] stage_place,
    input logic [RW-1:0] stage_dur,
    input logic [RW-1:0] act_dur,
    input logic          clamp_en,
    input logic [RW-1:0] target_r,
    input logic [RW-1:0] target_g,
    input logic [RW-1:0] target_b
);
    logic [RW:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_cnt <= '0;
        else if (trail)    run_cnt <= '0;
        else if (clamp_en) run_cnt <= run_cnt + 1'b1;
        else               run_cnt <= '0;
    end

    // R2
    place_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trail |=> (clamp_en == ($past(stage_place) == '0 && $past(stage_dur) != '0)));

    // R3
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_en |-> (run_cnt < {1'b0, act_dur}));

    // R5
    target_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (target_r == CODE_GND || target_r == CODE_MID) &&
        (target_g == CODE_GND || target_g == CODE_MID) &&
        (target_b == CODE_GND || target_b == CODE_MID));

    // R8
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trail |=> $stable({target_r, target_g, target_b}));
endmodule

bind clamp_pulse_gen clamp_pulse_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trail      (trail),
    .stage_place(stage_cfg.place),
    .stage_dur  (stage_cfg.dur),
    .act_dur    (act_cfg.dur),
    .clamp_en   (clamp_en),
    .target_r   (target_r),
    .target_g   (target_g),
    .target_b   (target_b)
);

// File: tb/clamp_pulse_gen_tb.sv
module clamp_pulse_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       clamp_en;
    logic [7:0] target_r, target_g, target_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    clamp_pulse_gen u_dut (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .clamp_en(clamp_en),
        .target_r(target_r), .target_g(target_g), .target_b(target_b)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] tgt_code(logic [7:0] sel, int ch);
        return sel[4 + ch] ? 8'h80 : 8'h00;
    endfunction

    function automatic bit in_win(int i, int b, int p, int d);
        return (d > 0) && (i >= b + 3 + p) && (i <= b + 3 + p + d - 1);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic tgt_chk(logic [7:0] sel, string tag);
        #1;
        chk({tag, " target_r"}, target_r, tgt_code(sel, 0));
        chk({tag, " target_g"}, target_g, tgt_code(sel, 1));
        chk({tag, " target_b"}, target_b, tgt_code(sel, 2));
    endtask

    // One line: sync active for sync_len cycles, then trailing edge; compare every cycle.
    task automatic run_line(int p, int d, bit ah, int sync_len, int rst_at,
                            int wr_at, logic [7:0] wa, logic [7:0] wd, string tag);
        int  bad = 0;
        int  first_i = -1;
        int  b2 = (rst_at >= 0) ? rst_at + 1 : 1 << 20;
        int  n = ((rst_at >= 0) ? rst_at + 1 : 0) + 3 + p + d + 4;
        bit  exp;
        @(negedge clk);
        hsync_in = ah;
        for (int i = 0; i < sync_len; i++) begin
            @(negedge clk);
            if (clamp_en !== 1'b0) bad++;
        end
        hsync_in = ~ah;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            exp = (i < b2 + 3) ? in_win(i, 0, p, d) : in_win(i, b2, p, d);
            if (clamp_en !== exp) begin
                bad++;
                if (first_i < 0) first_i = i;
            end
            if (i == rst_at)     hsync_in = ah;
            if (i == rst_at + 1) hsync_in = ~ah;
            if (i == wr_at) begin reg_wr_en = 1'b1; reg_addr = wa; reg_wdata = wd; end
            if (i == wr_at + 1) reg_wr_en = 1'b0;
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s clamp mismatches actual=%0d expected=0 (first at cycle %0d, P=%0d D=%0d)",
                     tag, bad, first_i, p, d);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [7:0] cur_sel;
        bit         cur_ah;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4 reset state
        #1;
        chk("R4 clamp_en", clamp_en, 0);
        tgt_chk(8'h00, "R4");
        rd_chk(8'h05, 8'h08, "R4 placement");
        rd_chk(8'h06, 8'h14, "R4 duration");
        rd_chk(8'h11, 8'h00, "R4 select");
        rd_chk(8'h12, 8'h01, "R4 sync ctrl");
        rd_chk(8'h33, 8'h00, "R9 unmapped");

        // R2 R3 default line
        run_line(8, 20, 1'b1, 6, -1, -1, 8'h00, 8'h00, "R2 R3 default");

        // R1 long sync with zero placement: nothing during sync
        wr(8'h05, 8'h00); wr(8'h06, 8'h05);
        run_line(0, 5, 1'b1, 40, -1, -1, 8'h00, 8'h00, "R1 R2 long sync P=0");

        // R3 zero duration
        wr(8'h05, 8'h03); wr(8'h06, 8'h00);
        run_line(3, 0, 1'b1, 6, -1, -1, 8'h00, 8'h00, "R3 zero duration");

        // R7 restart during clamp and during placement
        wr(8'h05, 8'h0A); wr(8'h06, 8'h14);
        run_line(10, 20, 1'b1, 6, 16, -1, 8'h00, 8'h00, "R7 restart in clamp");
        run_line(10, 20, 1'b1, 6, 5, -1, 8'h00, 8'h00, "R7 restart in wait");

        // R8 mid-line write does not change current line; next line uses it
        run_line(10, 20, 1'b1, 6, -1, 5, 8'h06, 8'h03, "R8 mid-line dur write");
        rd_chk(8'h06, 8'h03, "R9 readback before use");
        run_line(10, 3, 1'b1, 6, -1, -1, 8'h00, 8'h00, "R8 next line new dur");

        // R5 R8 targets
        wr(8'h11, 8'hFF);
        tgt_chk(8'h00, "R8 targets held");
        rd_chk(8'h11, 8'hFF, "R5 R9 select readback");
        run_line(10, 3, 1'b1, 6, -1, -1, 8'h00, 8'h00, "R5 line");
        tgt_chk(8'hFF, "R5 all midscale");
        wr(8'h11, 8'h8F);
        run_line(10, 3, 1'b1, 6, -1, -1, 8'h00, 8'h00, "R5 line2");
        tgt_chk(8'h8F, "R5 other bits no effect");
        rd_chk(8'h11, 8'h8F, "R5 other bits readback");

        // R6 active-low sync
        wr(8'h12, 8'hFE);
        rd_chk(8'h12, 8'h00, "R6 sync ctrl readback");
        @(negedge clk); hsync_in = 1'b1;
        repeat (30) @(negedge clk);
        run_line(10, 3, 1'b0, 6, -1, -1, 8'h00, 8'h00, "R6 active-low line");
        cur_ah = 1'b0;
        cur_sel = 8'h8F;

        // Random lines
        for (int k = 0; k < 24; k++) begin
            int p = $urandom_range(0, 30);
            int d = $urandom_range(0, 30);
            bit ah = 1'($urandom_range(0, 1));
            logic [7:0] sel = 8'($urandom);
            if (ah != cur_ah) begin
                wr(8'h12, {7'($urandom), ah});
                @(negedge clk); hsync_in = ~ah;
                repeat (70) @(negedge clk);
                cur_ah = ah;
            end
            wr(8'h05, 8'(p)); wr(8'h06, 8'(d)); wr(8'h11, sel);
            tgt_chk(cur_sel, "R8 random held");
            run_line(p, d, ah, $urandom_range(1, 12), -1, -1, 8'h00, 8'h00,
                     "R2 R3 R6 random");
            tgt_chk(sel, "R5 random");
            cur_sel = sel;
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule